// File: doc/BRIEF.md
# If-Then Block Condition Sequencer

This block follows a short predicated region opened by an if-then instruction. When that instruction retires, the block receives a base condition code, a slot count of one to four, and a then/else pattern for the slots after the first. For every instruction that follows, until the region is used up, it reports the condition that applies to that instruction. It also reports whether that condition passes against the current NZCV flags, and whether the instruction lies inside a region at all.

The region's progress is held in one 8-bit state word. The state shows on a port and can be written back through a load port, so an interrupt handler can save it and restore it later. The state then advances one slot per retired instruction. A taken branch that leaves the region before its final slot is reported as an error, and so is a request that pairs the always-true condition with an else slot.

Top module: `it_cond_seq`

## Requirements
- R1: After reset, in_blk_o is 0, pass_o is 1, cur_cond_o is 4'hE (always), state_o is 8'h00 and err_o is 0.
- R2: A legal start_i makes in_blk_o 1 from the next cycle, and cur_cond_o then equals start_cond_i for the first following instruction.
- R3: For slot k+1 (k = 1..3), else_i[k-1] = 1 selects the base condition with bit 0 inverted, and 0 selects the base condition unchanged. The 8-bit state is {cond[3:1], cond[0] of the current slot, remaining then/else bits, terminator 1, zero fill}.
- R4: len_i encodes the slot count minus one. in_blk_o stays 1 for exactly len_i+1 retirements and is 0 after the last one.
- R5: Flags are N = flags_i[3], Z = [2], C = [1], V = [0]. Codes 0..15 are EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, always, and reserved. The reserved code passes like always. pass_o gives the result for cur_cond_o in the usual way.
- R6: Outside a region, pass_o is 1 and cur_cond_o is 4'hE, whatever the flags are.
- R7: A start with base code 4'hE that marks any used slot as else raises err_o for one cycle and leaves the state unchanged. Else bits beyond the slot count are ignored.
- R8: A retirement with branch_i = 1 inside a region, before its last slot, raises err_o for one cycle and ends the region. On the last slot it raises no error.
- R9: state_o always shows the state. load_i replaces it with load_state_i in the next cycle, and load_i takes priority over start_i and retire_i.
- R10: retire_i outside a region has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flags_i | input | 4 | NZCV flags |
| start_i | input | 1 | If-then instruction retires |
| start_cond_i | input | 4 | Base condition code |
| len_i | input | 2 | Slot count minus one |
| else_i | input | 3 | Else marks for slots 2..4 |
| retire_i | input | 1 | Instruction retires |
| branch_i | input | 1 | Retiring instruction is a taken branch |
| load_i | input | 1 | Restore state |
| load_state_i | input | 8 | State to restore |
| state_o | output | 8 | Current state, for saving |
| in_blk_o | output | 1 | Current instruction lies inside a region |
| cur_cond_o | output | 4 | Condition for the current instruction |
| pass_o | output | 1 | Condition passes on flags_i |
| err_o | output | 1 | Illegal start or branch out of a region |

## Verification
The hardest case to reach from the ports is a region that is interrupted partway through and then resumed. The stimulus has to open a four-slot region, retire into its middle, capture state_o, and replace the state through a load. It then loads the captured word back and checks that the remaining slot conditions carry on in order. The sixteen condition codes are each evaluated through a loaded single-slot state, which reaches the reserved code that no legal start can produce.

// File: rtl/it_cond_seq.sv
module it_cond_seq #(
  parameter int CW = 4,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    flags_i,
  input  logic          start_i,
  input  logic [CW-1:0] start_cond_i,
  input  logic [1:0]    len_i,
  input  logic [2:0]    else_i,
  input  logic          retire_i,
  input  logic          branch_i,
  input  logic          load_i,
  input  logic [SW-1:0] load_state_i,
  output logic [SW-1:0] state_o,
  output logic          in_blk_o,
  output logic [CW-1:0] cur_cond_o,
  output logic          pass_o,
  output logic          err_o
);
  localparam logic [CW-1:0] ALWAYS = 4'hE;

  logic [SW-1:0] st_q, st_d, st_new;
  logic          err_q, err_d;
  logic [2:0]    used;
  logic [2:0]    lsb;
  logic          illegal, active, last;

  assign active = |st_q[3:0];
  assign last   = active && (st_q[2:0] == 3'b000);

  always_comb begin
    case (len_i)
      2'd0:    used = 3'b000;
      2'd1:    used = 3'b001;
      2'd2:    used = 3'b011;
      default: used = 3'b111;
    endcase
  end

  assign illegal = (start_cond_i == ALWAYS) && |(else_i & used);
  assign lsb     = {3{start_cond_i[0]}} ^ else_i;

  always_comb begin
    st_new[7:5] = start_cond_i[3:1];
    case (len_i)
      2'd0:    st_new[4:0] = {start_cond_i[0], 4'b1000};
      2'd1:    st_new[4:0] = {start_cond_i[0], lsb[0], 3'b100};
      2'd2:    st_new[4:0] = {start_cond_i[0], lsb[0], lsb[1], 2'b10};
      default: st_new[4:0] = {start_cond_i[0], lsb[0], lsb[1], lsb[2], 1'b1};
    endcase
  end

  always_comb begin
    st_d  = st_q;
    err_d = 1'b0;
    if (load_i) begin
      st_d = load_state_i;
    end else if (start_i) begin
      if (illegal) err_d = 1'b1;
      else         st_d  = st_new;
    end else if (retire_i && active) begin
      if (branch_i && !last) begin
        st_d  = '0;
        err_d = 1'b1;
      end else if (last) begin
        st_d = '0;
      end else begin
        st_d = {st_q[7:5], st_q[3:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  function automatic logic eval(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  eval = z;
      4'd1:  eval = !z;
      4'd2:  eval = cy;
      4'd3:  eval = !cy;
      4'd4:  eval = n;
      4'd5:  eval = !n;
      4'd6:  eval = v;
      4'd7:  eval = !v;
      4'd8:  eval = cy && !z;
      4'd9:  eval = !cy || z;
      4'd10: eval = (n == v);
      4'd11: eval = (n != v);
      4'd12: eval = !z && (n == v);
      4'd13: eval = z || (n != v);
      default: eval = 1'b1;
    endcase
  endfunction

  assign state_o    = st_q;
  assign in_blk_o   = active;
  assign cur_cond_o = active ? st_q[7:4] : ALWAYS;
  assign pass_o     = active ? eval(st_q[7:4], flags_i) : 1'b1;
  assign err_o      = err_q;
endmodule

// File: rtl/it_cond_seq_chk.sv
module it_cond_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [3:0] start_cond_i,
  input logic [1:0] len_i,
  input logic [2:0] else_i,
  input logic       retire_i,
  input logic       branch_i,
  input logic       load_i,
  input logic [7:0] load_state_i,
  input logic [7:0] state_o,
  input logic       in_blk_o,
  input logic [3:0] cur_cond_o,
  input logic       pass_o,
  input logic       err_o
);
  logic al_else;
  assign al_else = (start_cond_i == 4'hE) && (
                   (len_i == 2'd1 && else_i[0]) ||
                   (len_i == 2'd2 && |else_i[1:0]) ||
                   (len_i == 2'd3 && |else_i));

  a_r6_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !in_blk_o |-> (pass_o && cur_cond_o == 4'hE));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> state_o == $past(load_state_i));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i && !al_else) |=> (in_blk_o && cur_cond_o == $past(start_cond_i)));

  a_r7_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !load_i && al_else) |=> (err_o && $stable(state_o)));

  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !start_i && !load_i && in_blk_o && state_o[2:0] == 3'b000) |=> (!in_blk_o && !err_o));

  a_r8_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && branch_i && !start_i && !load_i && in_blk_o && state_o[2:0] != 3'b000) |=> (err_o && !in_blk_o));

  a_r10_idle_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !start_i && !load_i && !in_blk_o) |=> $stable(state_o));
endmodule

bind it_cond_seq it_cond_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_cond_i(start_cond_i),
  .len_i(len_i), .else_i(else_i), .retire_i(retire_i), .branch_i(branch_i),
  .load_i(load_i), .load_state_i(load_state_i), .state_o(state_o),
  .in_blk_o(in_blk_o), .cur_cond_o(cur_cond_o), .pass_o(pass_o), .err_o(err_o)
);

// File: tb/sim_it_cond_seq.sv
module sim_it_cond_seq;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] flags_i = '0, start_cond_i = '0;
  logic start_i = 0, retire_i = 0, branch_i = 0, load_i = 0;
  logic [1:0] len_i = '0;
  logic [2:0] else_i = '0;
  logic [7:0] load_state_i = '0;
  logic [7:0] state_o;
  logic in_blk_o, pass_o, err_o;
  logic [3:0] cur_cond_o;
  int checks = 0, errors = 0;
  logic [7:0] saved;

  always #(CLK_NS/2) clk = ~clk;

  it_cond_seq u0 (.*);

  // {cond, NZCV, expected pass} for R5
  localparam logic [8:0] VEC [21] = '{
    {4'd0, 4'b0100, 1'b1}, {4'd0, 4'b0000, 1'b0}, {4'd1, 4'b0000, 1'b1},
    {4'd2, 4'b0010, 1'b1}, {4'd3, 4'b0010, 1'b0}, {4'd4, 4'b1000, 1'b1},
    {4'd5, 4'b1000, 1'b0}, {4'd6, 4'b0001, 1'b1}, {4'd7, 4'b0001, 1'b0},
    {4'd8, 4'b0010, 1'b1}, {4'd8, 4'b0110, 1'b0}, {4'd9, 4'b0110, 1'b1},
    {4'd9, 4'b0010, 1'b0}, {4'd10, 4'b1001, 1'b1}, {4'd11, 4'b1000, 1'b1},
    {4'd11, 4'b1001, 1'b0}, {4'd12, 4'b0000, 1'b1}, {4'd12, 4'b0100, 1'b0},
    {4'd13, 4'b0001, 1'b1}, {4'd14, 4'b1111, 1'b1}, {4'd15, 4'b0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    start_i = 0; retire_i = 0; branch_i = 0; load_i = 0;
  endtask

  task automatic begin_blk(input logic [3:0] c, input logic [1:0] n, input logic [2:0] e);
    start_i = 1; start_cond_i = c; len_i = n; else_i = e; tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    #(CLK_NS * 2 + 1); rst_n = 1; #1;
    chk("R1 in_blk", {7'd0, in_blk_o}, 8'd0);
    chk("R1 pass", {7'd0, pass_o}, 8'd1);
    chk("R1 cond", {4'd0, cur_cond_o}, 8'h0E);
    chk("R1 state", state_o, 8'h00);
    chk("R1 err", {7'd0, err_o}, 8'd0);

    flags_i = 4'b0000; #1;
    chk("R6 idle pass", {7'd0, pass_o}, 8'd1);
    retire_i = 1; tick();
    chk("R10 idle retire", state_o, 8'h00);

    foreach (VEC[i]) begin
      load_i = 1; load_state_i = {VEC[i][8:5], 4'b1000}; tick();
      flags_i = VEC[i][4:1]; #1;
      chk("R5 cond", {4'd0, cur_cond_o}, {4'd0, VEC[i][8:5]});
      chk("R5 pass", {7'd0, pass_o}, {7'd0, VEC[i][0]});
    end
    retire_i = 1; tick();
    chk("R4 single slot end", {7'd0, in_blk_o}, 8'd0);

    // EQ, 4 slots, slot 3 else: EQ EQ NE EQ
    flags_i = 4'b0100;
    begin_blk(4'd0, 2'd3, 3'b010);
    chk("R2 in_blk", {7'd0, in_blk_o}, 8'd1);
    chk("R3 state word", state_o, 8'h05);
    chk("R2 slot1", {4'd0, cur_cond_o}, 8'h00);
    chk("R5 slot1 pass", {7'd0, pass_o}, 8'd1);
    retire_i = 1; tick();
    chk("R3 slot2", {4'd0, cur_cond_o}, 8'h00);
    retire_i = 1; tick();
    chk("R3 slot3 else", {4'd0, cur_cond_o}, 8'h01);
    chk("R3 slot3 pass", {7'd0, pass_o}, 8'd0);
    retire_i = 1; tick();
    chk("R3 slot4", {4'd0, cur_cond_o}, 8'h00);
    chk("R4 still in", {7'd0, in_blk_o}, 8'd1);
    retire_i = 1; tick();
    chk("R4 ended", {7'd0, in_blk_o}, 8'd0);
    chk("R4 state clear", state_o, 8'h00);

    // GT then else(LE), 2 slots
    begin_blk(4'd12, 2'd1, 3'b001);
    chk("R2 GT", {4'd0, cur_cond_o}, 8'h0C);
    retire_i = 1; tick();
    chk("R3 LE", {4'd0, cur_cond_o}, 8'h0D);
    retire_i = 1; tick();
    chk("R4 two slots", {7'd0, in_blk_o}, 8'd0);

    // illegal AL with else
    begin_blk(4'hE, 2'd1, 3'b001);
    chk("R7 err", {7'd0, err_o}, 8'd1);
    chk("R7 state kept", state_o, 8'h00);
    tick();
    chk("R7 err pulse", {7'd0, err_o}, 8'd0);
    begin_blk(4'hE, 2'd0, 3'b111);
    chk("R7 unused else ok", {7'd0, err_o}, 8'd0);
    chk("R7 AL in block", {7'd0, in_blk_o}, 8'd1);
    retire_i = 1; tick();

    // branch before last slot
    begin_blk(4'd0, 2'd2, 3'b000);
    retire_i = 1; tick();
    retire_i = 1; branch_i = 1; tick();
    chk("R8 mid branch err", {7'd0, err_o}, 8'd1);
    chk("R8 mid branch ends", {7'd0, in_blk_o}, 8'd0);
    // branch on last slot
    begin_blk(4'd1, 2'd0, 3'b000);
    retire_i = 1; branch_i = 1; tick();
    chk("R8 last branch ok", {7'd0, err_o}, 8'd0);
    chk("R8 last branch ends", {7'd0, in_blk_o}, 8'd0);

    // save / restore mid-block: CS, 4 slots, slot2 else -> CS CC CS CS
    begin_blk(4'd2, 2'd3, 3'b001);
    retire_i = 1; tick();
    saved = state_o;
    chk("R9 mid cond", {4'd0, cur_cond_o}, 8'h03);
    load_i = 1; load_state_i = 8'h00; tick();
    chk("R9 cleared", {7'd0, in_blk_o}, 8'd0);
    load_i = 1; load_state_i = saved; tick();
    chk("R9 restored", state_o, saved);
    chk("R9 resume cond", {4'd0, cur_cond_o}, 8'h03);
    retire_i = 1; tick();
    chk("R9 resume next", {4'd0, cur_cond_o}, 8'h02);
    retire_i = 1; tick();
    retire_i = 1; tick();
    chk("R9 resume end", {7'd0, in_blk_o}, 8'd0);

    // load beats start
    load_i = 1; load_state_i = 8'h00; start_i = 1; start_cond_i = 4'd4; len_i = 2'd1; else_i = 3'b000;
    tick();
    chk("R9 load priority", {7'd0, in_blk_o}, 8'd0);

    summary();
  end
endmodule